// File: doc/BRIEF.md
# Register Remap Lookup Unit

The unit translates the 5-bit register field of an instruction into a 6-bit physical register number. It holds one 32-row table for the integer class and one for the floating-point class. A lookup picks the table by class and reads the row addressed by the key. An inactive row passes the key through unchanged. An active scalar row substitutes its stored target. An active vector row substitutes its target plus the element loop offset of the current iteration.

Rows are loaded through a synchronous configuration port that takes one packed word per cycle. Loading a row makes it active. A single clear input deactivates every row in both tables. Each row also stores an element-width code and a packed flag. The unit does not act on these two fields and only reports them beside the remapped register, so that downstream logic can use them. The lookup path is purely combinational.

Top module: `reg_remap_unit`

## Requirements
- R1: The configuration word is laid out as follows: bit 0 is the class (0 integer, 1 floating-point), bits 5:1 the key, bits 11:6 the target, bit 12 the vector flag, bit 13 the packed flag, and bits 15:14 the element width (0 8-bit, 1 default, 2 half default, 3 double default). The class bit selects the table written, and `lk_fp_i` selects the table read.
- R2: A lookup of an inactive row returns the key zero-extended to 6 bits, with `elw_o`=1, `pack_o`=0 and `wrap_o`=0.
- R3: A lookup of an active scalar row returns the stored target, independent of `loop_offs_i`, with `wrap_o`=0.
- R4: A lookup of an active vector row returns (target + `loop_offs_i`) modulo 64.
- R5: `wrap_o` is 1 only for an active vector row whose target + `loop_offs_i` exceeds 63.
- R6: For an active row, `elw_o` and `pack_o` report the stored element width and packed flag.
- R7: A write takes effect at the clock edge and marks the row active. A lookup of the same row in the same cycle returns the old contents.
- R8: `clr_i` deactivates all rows of both tables at the next edge. In that cycle it takes precedence over a simultaneous write for the active bit.
- R9: After reset all rows in both tables are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_word_i | input | 16 | Packed configuration entry |
| clr_i | input | 1 | Deactivate all rows |
| lk_fp_i | input | 1 | Lookup class: 1 selects floating-point |
| lk_key_i | input | 5 | Architectural register key |
| loop_offs_i | input | 6 | Element loop offset |
| phys_o | output | 6 | Physical register number |
| wrap_o | output | 1 | Vector sum exceeded 63 |
| elw_o | output | 2 | Reported element-width code |
| pack_o | output | 1 | Reported packed flag |

## Verification
The wrap assertion assumes that the loop offset has the same width as the target. With that width, a wrapped sum is always smaller than the offset. The clear-related assertions assume that the clear and write inputs are never X once reset is released. The stimulus drives every input to a known value from time zero and changes inputs only on falling edges. The sweeps cover every key of both classes at offsets 0, 17 and 63, which reach both sides of the wrap boundary.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int unsigned KEY_W = 5;
  localparam int unsigned IDX_W = 6;
  localparam int unsigned EW_W  = 2;

  typedef struct packed {
    logic [EW_W-1:0]  elw;
    logic [IDX_W-1:0] tgt;
    logic             vec;
    logic             pk;
  } entry_t;
endpackage

// File: rtl/remap_table.sv
module remap_table
  import remap_pkg::*;
#(
  parameter int unsigned DEPTH = 1 << KEY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             clr_i,
  input  logic [KEY_W-1:0] wkey_i,
  input  entry_t           wdata_i,
  input  logic [KEY_W-1:0] rkey_i,
  output entry_t           rdata_o,
  output logic             ract_o
);
  entry_t           mem [DEPTH];
  logic [DEPTH-1:0] act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (we_i) mem[wkey_i] <= wdata_i;
      if (clr_i)     act <= '0;
      else if (we_i) act[wkey_i] <= 1'b1;
    end
  end

  assign rdata_o = mem[rkey_i];
  assign ract_o  = act[rkey_i];

  assert_write_sets_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !clr_i) |=> act[$past(wkey_i)]);
  assert_clear_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (act == '0));
endmodule

// File: rtl/remap_resolve.sv
module remap_resolve
  import remap_pkg::*;
(
  input  logic             act_i,
  input  entry_t           ent_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [IDX_W-1:0] offs_i,
  output logic [IDX_W-1:0] phys_o,
  output logic             wrap_o,
  output logic [EW_W-1:0]  elw_o,
  output logic             pack_o
);
  localparam logic [EW_W-1:0] ELW_DFLT = EW_W'(1);
  logic [IDX_W:0] sum;

  assign sum = {1'b0, ent_i.tgt} + {1'b0, offs_i};

  always_comb begin
    phys_o = IDX_W'(key_i);
    wrap_o = 1'b0;
    elw_o  = ELW_DFLT;
    pack_o = 1'b0;
    if (act_i) begin
      elw_o  = ent_i.elw;
      pack_o = ent_i.pk;
      if (ent_i.vec) begin
        phys_o = sum[IDX_W-1:0];
        wrap_o = sum[IDX_W];
      end else begin
        phys_o = ent_i.tgt;
      end
    end
  end
endmodule

// File: rtl/reg_remap_unit.sv
module reg_remap_unit
  import remap_pkg::*;
#(
  parameter int unsigned NUM_CLS = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [15:0] cfg_word_i,
  input  logic        clr_i,
  input  logic        lk_fp_i,
  input  logic [4:0]  lk_key_i,
  input  logic [5:0]  loop_offs_i,
  output logic [5:0]  phys_o,
  output logic        wrap_o,
  output logic [1:0]  elw_o,
  output logic        pack_o
);
  localparam int unsigned KEY_LO = 1;
  localparam int unsigned TGT_LO = KEY_LO + KEY_W;
  localparam int unsigned VEC_B  = TGT_LO + IDX_W;
  localparam int unsigned PK_B   = VEC_B + 1;
  localparam int unsigned EW_LO  = PK_B + 1;

  logic             w_cls;
  logic [KEY_W-1:0] w_key;
  entry_t           w_ent;
  entry_t           rd  [NUM_CLS];
  logic             ract[NUM_CLS];

  assign w_cls     = cfg_word_i[0];
  assign w_key     = cfg_word_i[TGT_LO-1:KEY_LO];
  assign w_ent.tgt = cfg_word_i[VEC_B-1:TGT_LO];
  assign w_ent.vec = cfg_word_i[VEC_B];
  assign w_ent.pk  = cfg_word_i[PK_B];
  assign w_ent.elw = cfg_word_i[EW_LO+EW_W-1:EW_LO];

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_tbl
    remap_table u_tbl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (cfg_we_i && (w_cls == 1'(g))),
      .clr_i   (clr_i),
      .wkey_i  (w_key),
      .wdata_i (w_ent),
      .rkey_i  (lk_key_i),
      .rdata_o (rd[g]),
      .ract_o  (ract[g])
    );
  end

  remap_resolve u_res (
    .act_i  (ract[lk_fp_i]),
    .ent_i  (rd[lk_fp_i]),
    .key_i  (lk_key_i),
    .offs_i (loop_offs_i),
    .phys_o (phys_o),
    .wrap_o (wrap_o),
    .elw_o  (elw_o),
    .pack_o (pack_o)
  );

  assert_wrap_below_offs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (phys_o < loop_offs_i));
  assert_cleared_identity_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> (phys_o == {1'b0, lk_key_i} && !wrap_o && !pack_o));
endmodule

// File: tb/sim_reg_remap_unit.sv
`timescale 1ns/1ps
module sim_reg_remap_unit;
  logic clk = 0, rst_ni = 0;
  logic cfg_we_i = 0, clr_i = 0, lk_fp_i = 0;
  logic [15:0] cfg_word_i = '0;
  logic [4:0] lk_key_i = '0;
  logic [5:0] loop_offs_i = '0;
  logic [5:0] phys_o;
  logic wrap_o, pack_o;
  logic [1:0] elw_o;
  int total = 0, fails = 0;

  bit       m_act [2][32];
  bit [5:0] m_tgt [2][32];
  bit       m_vec [2][32];
  bit       m_pk  [2][32];
  bit [1:0] m_elw [2][32];

  always #2.5 clk = ~clk;

  reg_remap_unit u0 (.*, .clk_i(clk));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic look(bit fp, int key, int offs, string req);
    int ep, ew, ee, ek, s;
    lk_fp_i = fp; lk_key_i = 5'(key); loop_offs_i = 6'(offs);
    #0.5;
    ep = key; ew = 0; ee = 1; ek = 0;
    if (m_act[fp][key]) begin
      ee = m_elw[fp][key]; ek = m_pk[fp][key];
      if (m_vec[fp][key]) begin
        s = m_tgt[fp][key] + offs; ep = s % 64; ew = (s > 63);
      end else ep = m_tgt[fp][key];
    end
    chk({req, " phys"}, phys_o, ep);
    chk({req, " wrap"}, wrap_o, ew);
    chk({req, " elw"}, elw_o, ee);
    chk({req, " pack"}, pack_o, ek);
  endtask

  task automatic wr(bit fp, int key, int elw, int tgt, bit vec, bit pk);
    @(negedge clk);
    cfg_we_i = 1;
    cfg_word_i = {2'(elw), pk, vec, 6'(tgt), 5'(key), fp};
  endtask

  task automatic commit(bit fp, int key, int elw, int tgt, bit vec, bit pk);
    @(posedge clk);
    m_act[fp][key] = !clr_i; m_tgt[fp][key] = 6'(tgt); m_vec[fp][key] = vec;
    m_pk[fp][key] = pk; m_elw[fp][key] = 2'(elw);
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  initial begin
    #(200000 * 5);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    for (int f = 0; f < 2; f++)
      for (int k = 0; k < 32; k++) look(f[0], k, 9, "R9 reset");

    // int table only: fp must stay identity (R1)
    for (int k = 0; k < 32; k++) begin
      wr(0, k, k % 4, (k * 7 + 3) % 64, k[0], k[1]);
      commit(0, k, k % 4, (k * 7 + 3) % 64, k[0], k[1]);
    end
    for (int k = 0; k < 32; k++) look(1, k, 5, "R1 fp untouched");
    for (int k = 0; k < 32; k++) begin
      wr(1, k, 3 - k % 4, (k * 5 + 40) % 64, !k[0], !k[1]);
      commit(1, k, 3 - k % 4, (k * 5 + 40) % 64, !k[0], !k[1]);
    end
    for (int f = 0; f < 2; f++)
      for (int k = 0; k < 32; k++) begin
        look(f[0], k, 0, "R3/R4/R6 offs0");
        look(f[0], k, 17, "R3/R4/R6 offs17");
        look(f[0], k, 63, "R4/R5 offs63");
      end

    // clear everything (R8)
    @(negedge clk); clr_i = 1;
    @(posedge clk);
    for (int f = 0; f < 2; f++) for (int k = 0; k < 32; k++) m_act[f][k] = 0;
    @(negedge clk); clr_i = 0;
    for (int f = 0; f < 2; f++)
      for (int k = 0; k < 32; k++) look(f[0], k, 40, "R8 cleared");

    // same-cycle write/lookup returns old (R7)
    wr(0, 3, 2, 60, 1, 1);
    look(0, 3, 10, "R7 old in write cycle");
    commit(0, 3, 2, 60, 1, 1);
    look(0, 3, 10, "R7 new after edge");
    chk("R5 wrap at 60+10", wrap_o, 1);
    look(0, 3, 3, "R4 no wrap at 60+3");
    chk("R5 no wrap at 60+3", wrap_o, 0);

    // clear beats simultaneous write (R8)
    wr(1, 7, 0, 12, 0, 1);
    clr_i = 1;
    commit(1, 7, 0, 12, 0, 1);
    clr_i = 0;
    for (int k = 0; k < 32; k++) m_act[0][k] = 0;
    look(1, 7, 0, "R8 clear wins");
    chk("R8 clear wins identity", phys_o, 7);
    look(0, 3, 0, "R8 int cleared");

    // scalar ignores offset (R3)
    wr(1, 31, 1, 63, 0, 0);
    commit(1, 31, 1, 63, 0, 0);
    for (int o = 0; o < 64; o += 9) look(1, 31, o, "R3 scalar");

    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule